// File: doc/BRIEF.md
# Constant-Coefficient Multiplier Built from Nibble Tables

This block multiplies a signed input word by a signed coefficient that is fixed when the design is elaborated. The input is cut into 4-bit slices. Each slice addresses its own 16-entry constant table, and each table entry holds the slice value multiplied by the coefficient. The table outputs are then merged by a chain of weighted adders. Each weighted adder lines up two partial results whose weights are powers of two. The low bits of the lower-weight operand go straight to the result. Only the remaining upper bits are summed with the higher-weight operand.

A build parameter picks one of two variants. The combinational variant produces the product in the same cycle. The pipelined variant registers every table output and every adder stage under a clock enable, with delay registers that keep all paths the same length. A valid flag follows the data through the pipeline and shows which output cycles carry a result.

Top module: `kcm_mult`

## Requirements
- R1: `product` equals the signed value of `din` times the signed coefficient `COEF` (a `K_W`-bit elaboration parameter), with no error, for every input value.
- R2: In the pipelined build, a word taken in with `in_vld` high on an edge where `ce` is high appears on `product`, with `out_vld` high, after exactly S edges that have `ce` high, where S = ceil(`IN_W`/4) (3 by default). Each accepted word gives exactly one result, and results come out in input order.
- R3: In the pipelined build, an edge with `ce` low leaves `out_vld` and a valid `product` unchanged, and `din`/`in_vld` presented during that cycle are not taken in.
- R4: In the pipelined build, a synchronous active-high `rst` clears `out_vld` on the next edge, including when the pipeline is full.
- R5: In the combinational build, `out_vld` equals `in_vld` and `product` follows `din` within the same cycle, with no dependence on `ce` or the clock.
- R6: The top slice is made of the input bits from `IN_W`-1 down to 4(S-1). It is sign-extended to 4 bits, treated as signed and weighted by 2^(4(S-1)). For the default width this is bits 10..8, with bit 10 repeated, at weight 2^8. Negative extremes such as -1024, -256 and -1 give exact products.
- R7: Each lower slice j (bits 4j+3..4j) is treated as unsigned and weighted by 2^(4j). A set bit 3 or bit 7 does not make a slice negative (inputs 15, 240 and 255 give exact products).
- R8: When the top slice is narrower than 4 bits (for example `IN_W`=10, which leaves a 2-bit top slice), table entries that no legal address reaches hold zero. Every product is still exact, including for the most negative coefficient.
- R9: `product[3:0]` equals the low four bits of `din[3:0]` times `COEF`, because the lowest slice's bottom nibble goes straight to the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flag |
| ce | input | 1 | Clock enable for every pipeline register |
| in_vld | input | 1 | Marks `din` as a word to multiply |
| din | input | IN_W | Signed multiplicand |
| out_vld | output | 1 | Marks `product` as a result |
| product | output | IN_W+K_W | Signed product din × COEF |

## Verification
The two events that can land on the same edge are a pipeline stall (`ce` low) and a result reaching the output, with a new valid word already waiting at the input. The bench repeatedly drops `ce` for several cycles in the middle of a full sweep, while `in_vld` stays high and `din` keeps changing. It then requires the held output to stay put and every later result to match the scoreboard's order, so no stalled word slips in. A reset that arrives while the pipeline holds valid words is also provoked. In that case `out_vld` must be low after the next edge.

// File: rtl/kcm_pkg.sv
package kcm_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Build variant of the multiplier.
    typedef enum logic {
        BUILD_COMB = 1'b0,
        BUILD_PIPE = 1'b1
    } build_e;

    // Width of one table index slice; each table therefore has 2**SLICE rows.
    localparam int SLICE = 4;
    localparam int ROWS  = 1 << SLICE;

    function automatic int slice_count(input int w);
        return (w + SLICE - 1) / SLICE;
    endfunction

    function automatic int top_width(input int w);
        return w - SLICE * (slice_count(w) - 1);
    endfunction

    // One table register stage plus one register per adder in the chain.
    function automatic int latency(input int w, input build_e b);
        return (b == BUILD_PIPE) ? slice_count(w) : 0;
    endfunction
endpackage

// File: rtl/kcm_delay.sv
module kcm_delay #(
    parameter int W       = 1,
    parameter int DEPTH   = 1,
    parameter bit HAS_RST = 1'b0
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    timeunit 1ns;
    timeprecision 1ps;

    if (DEPTH == 0) begin : g_wire
        assign q = d;
        logic unused_ctl;
        assign unused_ctl = &{1'b0, clk, rst, ce};
    end else begin : g_regs
        logic [W-1:0] stg [DEPTH];
        always_ff @(posedge clk) begin
            if (HAS_RST && rst) begin
                for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
            end else if (ce) begin
                stg[0] <= d;
                for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
            end
        end
        assign q = stg[DEPTH-1];
    end
endmodule

// File: rtl/kcm_nibble_rom.sv
module kcm_nibble_rom import kcm_pkg::*; #(
    parameter int PW          = 15,
    parameter int COEF        = -619,
    parameter int SLICE_W     = 4,
    parameter bit SIGNED_ADDR = 1'b0
)(
    input  logic [SLICE-1:0]     addr,
    output logic signed [PW-1:0] data
);
    timeunit 1ns;
    timeprecision 1ps;

    logic signed [PW-1:0] rom [ROWS];

    // Constant rows; addresses a slice of SLICE_W bits never produces are zero.
    for (genvar a = 0; a < ROWS; a++) begin : g_row
        localparam int  SA    = (SIGNED_ADDR && a >= ROWS / 2) ? a - ROWS : a;
        localparam bit  INUSE = SIGNED_ADDR
                              ? (SA >= -(1 << (SLICE_W - 1)) && SA < (1 << (SLICE_W - 1)))
                              : (a < (1 << SLICE_W));
        localparam int  VAL   = INUSE ? SA * COEF : 0;
        assign rom[a] = PW'(VAL);
    end

    assign data = rom[addr];
endmodule

// File: rtl/kcm_wadd.sv
module kcm_wadd #(
    parameter int VW   = 22,
    parameter int WT_A = 0,
    parameter int WT_B = 4
)(
    input  logic signed [VW-1:0] a,
    input  logic signed [VW-1:0] b,
    output logic signed [VW-1:0] s
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int D = (WT_A > WT_B) ? WT_A - WT_B : WT_B - WT_A;

    logic signed [VW-1:0] hi;
    logic signed [VW-1:0] lo;

    // Order operands so that hi carries the larger weight.
    if (WT_A >= WT_B) begin : g_keep
        assign hi = a;
        assign lo = b;
    end else begin : g_swap
        assign hi = b;
        assign lo = a;
    end

    if (D == 0) begin : g_plain
        assign s = hi + lo;
    end else begin : g_bypass
        // Low D bits of the lighter operand skip the adder entirely.
        logic [VW-D-1:0] upper;
        assign upper = hi[VW-D-1:0] + lo[VW-1:D];
        assign s     = {upper, lo[D-1:0]};
        logic unused_hi;
        assign unused_hi = ^hi[VW-1:VW-D];
    end
endmodule

// File: rtl/kcm_mult.sv
module kcm_mult import kcm_pkg::*; #(
    parameter int     IN_W  = 11,
    parameter int     K_W   = 11,
    parameter int     COEF  = -619,
    parameter build_e BUILD = BUILD_PIPE,
    localparam int    OUT_W = IN_W + K_W
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  logic                    in_vld,
    input  logic signed [IN_W-1:0]  din,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] product
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NS    = slice_count(IN_W);
    localparam int TW    = top_width(IN_W);
    localparam int PW    = K_W + SLICE;
    localparam bit PIPED = (BUILD == BUILD_PIPE);
    localparam int LAT   = latency(IN_W, BUILD);

    logic signed [TW-1:0]    top_raw;
    logic [SLICE-1:0]        sl_addr [NS];
    logic signed [PW-1:0]    tbl     [NS];
    logic signed [PW-1:0]    ptab    [NS];
    logic signed [OUT_W-1:0] acc     [NS];

    assign top_raw = din[IN_W-1 -: TW];

    // Slice decode, table lookup and table register stage.
    for (genvar j = 0; j < NS; j++) begin : g_slice
        localparam bit IS_TOP = (j == NS - 1);
        localparam int SW     = IS_TOP ? TW : SLICE;

        if (IS_TOP) begin : g_top
            assign sl_addr[j] = SLICE'(top_raw);
        end else begin : g_low
            assign sl_addr[j] = din[SLICE*j +: SLICE];
        end

        kcm_nibble_rom #(
            .PW(PW), .COEF(COEF), .SLICE_W(SW), .SIGNED_ADDR(IS_TOP)
        ) u_rom (
            .addr(sl_addr[j]), .data(tbl[j])
        );

        kcm_delay #(.W(PW), .DEPTH(PIPED ? 1 : 0), .HAS_RST(1'b0)) u_treg (
            .clk(clk), .rst(rst), .ce(ce), .d(tbl[j]), .q(ptab[j])
        );
    end

    // Weighted chain from the top slice downward.
    assign acc[0] = OUT_W'(ptab[NS-1]);

    for (genvar k = 1; k < NS; k++) begin : g_stage
        localparam int LO = NS - 1 - k;
        logic signed [PW-1:0]    lo_al;
        logic signed [OUT_W-1:0] sum;

        kcm_delay #(.W(PW), .DEPTH(PIPED ? k - 1 : 0), .HAS_RST(1'b0)) u_bal (
            .clk(clk), .rst(rst), .ce(ce), .d(ptab[LO]), .q(lo_al)
        );

        kcm_wadd #(
            .VW(OUT_W), .WT_A(SLICE * LO), .WT_B(SLICE * (LO + 1))
        ) u_add (
            .a(OUT_W'(lo_al)), .b(acc[k-1]), .s(sum)
        );

        kcm_delay #(.W(OUT_W), .DEPTH(PIPED ? 1 : 0), .HAS_RST(1'b0)) u_areg (
            .clk(clk), .rst(rst), .ce(ce), .d(sum), .q(acc[k])
        );
    end

    assign product = acc[NS-1];

    kcm_delay #(.W(1), .DEPTH(LAT), .HAS_RST(1'b1)) u_vld (
        .clk(clk), .rst(rst), .ce(ce), .d(in_vld), .q(out_vld)
    );
endmodule

// File: rtl/kcm_chk.sv
module kcm_chk import kcm_pkg::*; #(
    parameter int     IN_W  = 11,
    parameter int     K_W   = 11,
    parameter int     COEF  = -619,
    parameter build_e BUILD = BUILD_PIPE
)(
    input logic                         clk,
    input logic                         rst,
    input logic                         ce,
    input logic                         in_vld,
    input logic signed [IN_W-1:0]       din,
    input logic                         out_vld,
    input logic signed [IN_W+K_W-1:0]   product
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LAT = latency(IN_W, BUILD);

    logic                   ref_vld;
    logic signed [IN_W-1:0] ref_din;
    logic signed [31:0]     ref_full;
    logic [31:0]            ref_low;

    if (LAT == 0) begin : g_now
        assign ref_vld = in_vld;
        assign ref_din = din;
        logic unused_ce;
        assign unused_ce = ce;
    end else begin : g_dly
        logic                   rv [LAT];
        logic signed [IN_W-1:0] rd [LAT];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < LAT; i++) rv[i] <= 1'b0;
            end else if (ce) begin
                rv[0] <= in_vld;
                for (int i = 1; i < LAT; i++) rv[i] <= rv[i-1];
            end
            if (ce) begin
                rd[0] <= din;
                for (int i = 1; i < LAT; i++) rd[i] <= rd[i-1];
            end
        end
        assign ref_vld = rv[LAT-1];
        assign ref_din = rd[LAT-1];
    end

    assign ref_full = 32'(ref_din) * COEF;
    assign ref_low  = {28'b0, ref_din[3:0]} * COEF;

    // R2 / R5: valid flag timing
    a_r2_valid_timing: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (out_vld == ref_vld));

    // R1: exact product
    a_r1_exact_product: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (32'(product) == ref_full));

    // R9: bottom nibble from lowest slice
    a_r9_low_nibble: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (product[3:0] == ref_low[3:0]));

    if (BUILD == BUILD_PIPE) begin : g_pipe_props
        // R3: stall freezes the output
        a_r3_stall_holds_vld: assert property (@(posedge clk) disable iff (rst)
            (!ce && !rst) |=> $stable(out_vld));
        a_r3_stall_holds_data: assert property (@(posedge clk) disable iff (rst)
            (!ce && !rst && out_vld) |=> $stable(product));

        // R4: reset clears the valid flag
        logic rst_seen;
        always_ff @(posedge clk) rst_seen <= rst;
        always @(negedge clk) begin
            if (rst_seen) begin
                a_r4_reset_clears: assert (!out_vld);
            end
        end
    end
endmodule

bind kcm_mult kcm_chk #(
    .IN_W(IN_W), .K_W(K_W), .COEF(COEF), .BUILD(BUILD)
) u_chk (.*);

// File: tb/sim_kcm_mult.sv
module sim_kcm_mult;
    import kcm_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IN_W   = 11;
    localparam int K_W    = 11;
    localparam int C0     = -619;
    localparam int OUT_W  = IN_W + K_W;
    localparam int IN_W1  = 10;
    localparam int C1     = -1024;
    localparam int OUT_W1 = IN_W1 + K_W;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce  = 1'b0;
    logic vld = 1'b0;
    logic signed [IN_W-1:0]   din = '0;
    logic                     out_vld;
    logic signed [OUT_W-1:0]  product;
    logic vld1 = 1'b0;
    logic signed [IN_W1-1:0]  din1 = '0;
    logic                     out_vld1;
    logic signed [OUT_W1-1:0] product1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct { int v; string r; } item_t;
    item_t exp_q[$];
    item_t mon_it;

    always #10 clk = ~clk;

    kcm_mult #(.IN_W(IN_W), .K_W(K_W), .COEF(C0), .BUILD(BUILD_PIPE)) u0 (
        .clk(clk), .rst(rst), .ce(ce), .in_vld(vld), .din(din),
        .out_vld(out_vld), .product(product)
    );

    kcm_mult #(.IN_W(IN_W1), .K_W(K_W), .COEF(C1), .BUILD(BUILD_COMB)) u1 (
        .clk(clk), .rst(rst), .ce(ce), .in_vld(vld1), .din(din1),
        .out_vld(out_vld1), .product(product1)
    );

    task automatic check(input bit ok, input string r, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at %0t", r, act, exp, $time);
        end
    endtask

    task automatic drive(input int v, input bit valid, input bit en, input string r);
        @(posedge clk);
        #2;
        din  = IN_W'(v);
        vld  = valid;
        ce   = en;
        din1 = IN_W1'(v);
        vld1 = valid;
        if (valid && en) exp_q.push_back('{v: v, r: r});
    endtask

    // Monitor: ce value seen at the last rising edge decides if a new result is due.
    logic ce_edge = 1'b0;
    always @(posedge clk) ce_edge <= ce;

    logic                    prev_vld  = 1'b0;
    logic signed [OUT_W-1:0] prev_prod = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (ce_edge) begin
                if (out_vld) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected result", 1, 0);
                    end else begin
                        mon_it = exp_q.pop_front();
                        check(int'(product) == mon_it.v * C0, mon_it.r,
                              product, mon_it.v * C0);
                        check(product[3:0] == 4'((mon_it.v & 15) * C0), "R9",
                              product[3:0], 4'((mon_it.v & 15) * C0));
                    end
                end
            end else begin
                check(out_vld == prev_vld, "R3 valid held", out_vld, prev_vld);
                if (prev_vld) check(product == prev_prod, "R3 data held", product, prev_prod);
            end
            // R5 / R8: combinational build with 2-bit top slice
            check(out_vld1 == vld1, "R5", out_vld1, vld1);
            if (vld1) check(int'(product1) == int'(din1) * C1, "R8",
                            product1, int'(din1) * C1);
        end
        prev_vld  = out_vld;
        prev_prod = product;
    end

    initial begin
        #(20 * 60000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog act=timeout exp=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    int    corners [10] = '{0, 1, -1, 1023, -1024, 255, 15, 240, -256, 256};
    string ctags   [10] = '{"R1", "R1", "R6", "R1", "R6", "R7", "R7", "R7", "R6", "R6"};

    initial begin
        // R4: reset state
        repeat (3) drive(0, 1'b0, 1'b0, "R4");
        @(negedge clk);
        check(out_vld == 1'b0, "R4 reset state", out_vld, 0);
        check(out_vld1 == 1'b0, "R5 reset state", out_vld1, 0);
        @(posedge clk);
        #2 rst = 1'b0;

        // R2: single word, exact latency, most negative input (R6)
        repeat (4) drive(0, 1'b0, 1'b1, "R2");
        drive(-1024, 1'b1, 1'b1, "R6");
        for (int i = 0; i <= LAT + 1; i++) begin
            @(negedge clk);
            if (i >= 1) check(out_vld == (i == LAT), "R2 latency", out_vld, (i == LAT));
            if (i == 1) begin vld = 1'b0; vld1 = 1'b0; end
        end

        // R6 / R7 corners, back to back
        for (int i = 0; i < 10; i++) drive(corners[i], 1'b1, 1'b1, ctags[i]);

        // R1 full sweep with stalls (R3) carrying valid, changing input
        for (int v = -1024; v < 1024; v++) begin
            if (v % 37 == 0) begin
                for (int s = 0; s < 3; s++) drive(v * 7 + s, 1'b1, 1'b0, "R3");
            end
            drive(v, 1'b1, 1'b1, "R1");
        end
        repeat (LAT + 3) drive(0, 1'b0, 1'b1, "R2");
        @(negedge clk);
        check(exp_q.size() == 0, "R2 all results delivered", exp_q.size(), 0);

        // R4: reset while the pipeline holds valid words
        drive(5, 1'b1, 1'b1, "R1");
        drive(-7, 1'b1, 1'b1, "R1");
        @(posedge clk);
        #2;
        rst  = 1'b1;
        vld  = 1'b0;
        vld1 = 1'b0;
        exp_q.delete();
        @(negedge clk);
        @(negedge clk);
        check(out_vld == 1'b0, "R4 reset mid-flight", out_vld, 0);
        @(posedge clk);
        #2 rst = 1'b0;

        // Recovery after reset
        drive(-300, 1'b1, 1'b1, "R1");
        repeat (LAT + 3) drive(0, 1'b0, 1'b1, "R2");
        @(negedge clk);
        check(exp_q.size() == 0, "R2 after reset", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule